// File: doc/BRIEF.md
# Passive SPI Bus Monitor

This block watches a four-wire SPI bus from the side and never drives it. A fast system clock oversamples the serial clock, both data lanes and the chip-select line through two-flop synchronisers. The block picks out the sampling edge named by the clock polarity and phase settings and assembles the bits of each lane into words of `WORD_BITS` bits, first bit at the most or least significant end. Every finished word leaves in a one-cycle pulse that carries both lane words, a presence flag per lane, a start and an end timestamp from a free-running cycle counter, and a warning flag.

Chip-select activity is reported on a second pulse as an event that holds the old and the new line level. One event after reset gives the initial level, or a pair of "unknown" codes when the block is built without a chip-select line. A third pulse gives the bit rate measured over each word, computed from the system clock frequency by a serial divider. The system clock must run at least four times faster than the serial clock. Either data lane or the chip-select line can be left out at build time, but at least one data lane must be present.

Top module: `spi_bus_monitor`

## Requirements
- R1: A bit is taken only on the rising serial-clock edge when `cfg_cpol == cfg_cpha` and only on the falling edge otherwise; cycles in which the serial clock level does not change take no bit.
- R2: `cfg_cs_act_high = 0` makes a low chip-select level active and a high level inactive; `cfg_cs_act_high = 1` reverses this.
- R3: `word_vld` pulses for one cycle after exactly `WORD_BITS` bits have been taken, and the next bit taken starts a new word.
- R4: With `cfg_lsb_first = 0` the k-th bit of a word (k counted from 0) lands at position `WORD_BITS-1-k`; with `cfg_lsb_first = 1` it lands at position k.
- R5: Any change of the chip-select level discards the partial words and the bit count and pulses `cs_evt_vld` with the old and new levels; the 2-bit level code is 2'b00 for low, 2'b01 for high and 2'b10 for unknown.
- R6: Once after reset, when the synchronisers have filled, one event reports old = 2'b10 and new = the current level code; a build without chip select reports 2'b10 for both.
- R7: `word_warn` is 1 exactly when chip select was at its inactive level on the sampling edge of the word's first bit.
- R8: A lane left out at build time gives a presence flag of 0 and a word of all zeros; a present lane gives a flag of 1.
- R9: `word_t_start` is the counter value of the first bit's sampling edge and `word_t_end` is the last bit's time plus the span from first to last bit, so `word_t_end - word_t_start` equals twice the first-to-last span.
- R10: `rate_bps` equals floor(`WORD_BITS` x `CLK_HZ` / (first-to-last span + 1)) and is delivered by a one-cycle `rate_vld` pulse after each word.
- R11: When a chip-select change and a sampling edge fall in the same cycle, the partial word is cleared first and that edge's bit becomes bit 0 of a new word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Serial clock phase: 0 leading edge, 1 trailing edge |
| cfg_cs_act_high | input | 1 | Chip-select active level |
| cfg_lsb_first | input | 1 | Bit order of a word |
| bus_sclk | input | 1 | Observed serial clock |
| bus_mosi | input | 1 | Observed controller-to-target data |
| bus_miso | input | 1 | Observed target-to-controller data |
| bus_cs | input | 1 | Observed chip select |
| word_vld | output | 1 | One-cycle pulse for a finished word |
| word_mosi | output | WORD_BITS | Controller-to-target word |
| word_miso | output | WORD_BITS | Target-to-controller word |
| word_mosi_ok | output | 1 | Controller-to-target lane present |
| word_miso_ok | output | 1 | Target-to-controller lane present |
| word_t_start | output | TS_W | Cycle stamp of the first bit |
| word_t_end | output | TS_W | Extrapolated end stamp of the last bit |
| word_warn | output | 1 | Chip select inactive at the first bit |
| cs_evt_vld | output | 1 | One-cycle pulse for a chip-select event |
| cs_evt_old | output | 2 | Previous level code |
| cs_evt_new | output | 2 | New level code |
| rate_vld | output | 1 | One-cycle pulse for a bit-rate result |
| rate_bps | output | RATE_W | Bits per second over the last word |

## Verification
A chip-select change and a sampling edge can land in the same system cycle, and the block must then clear the old partial word and still keep that edge's bit as the first bit of the new word. The bench drives the chip-select line to its active level at the same instant as the first leading edge of a mode 0 transfer, so both travel through equal synchronisers and arrive together. It then judges that one event reports the new level, that exactly one word follows with the full byte intact, and that its warning flag is clear because the new, active level is the one seen on the first bit.

// File: rtl/spi_mon_pkg.sv
package spi_mon_pkg;

   // Two-bit chip-select level code used on the event outputs.
   typedef logic [1:0] cs_code_t;

   localparam cs_code_t CS_CODE_LOW     = 2'b00;
   localparam cs_code_t CS_CODE_HIGH    = 2'b01;
   localparam cs_code_t CS_CODE_UNKNOWN = 2'b10;

   function automatic cs_code_t cs_level_code(input logic lvl);
      return {1'b0, lvl};
   endfunction

endpackage

// File: rtl/spi_mon_sync.sv
module spi_mon_sync #(
   parameter int N      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] d,
   output logic [N-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("spi_mon_sync: STAGES must be at least 2");
   end
   if (N < 1) begin : g_bad_width
      $error("spi_mon_sync: N must be at least 1");
   end

   for (genvar b = 0; b < N; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[STAGES-2:0], d[b]};
      end
      assign q[b] = chain[STAGES-1];
   end

endmodule

// File: rtl/spi_mon_lane.sv
module spi_mon_lane #(
   parameter int W  = 8,
   parameter int IW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          take,
   input  logic          first,
   input  logic [IW-1:0] idx,
   input  logic          lsb_first,
   input  logic          bit_in,
   output logic [W-1:0]  word_nx
);

   if (W < 1) begin : g_bad_w
      $error("spi_mon_lane: W must be at least 1");
   end

   logic [W-1:0] acc;
   logic [W-1:0] hit;
   logic [W-1:0] base;

   // One decoder per bit position; order selects which index maps here.
   for (genvar p = 0; p < W; p++) begin : g_pos
      assign hit[p] = take & bit_in &
                      (lsb_first ? (idx == IW'(p)) : (idx == IW'(W - 1 - p)));
   end

   assign base    = (clr | (take & first)) ? '0 : acc;
   assign word_nx = base | hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc <= '0;
      else        acc <= word_nx;
   end

   // R5: a chip-select change without a bit empties the partial word
   p_clear_on_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !take) |=> (acc == '0));

   // R1: no sampling edge and no clear leaves the partial word untouched
   p_hold_no_edge_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !take) |=> $stable(acc));

endmodule

// File: rtl/spi_mon_rate.sv
module spi_mon_rate #(
   parameter logic [63:0] NUM   = 64'd1600000000,
   parameter int          NUM_W = 31,
   parameter int          DEN_W = 32,
   parameter int          OUT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [DEN_W-1:0] den,
   output logic [OUT_W-1:0] rate,
   output logic             done
);

   localparam int IW = $clog2(NUM_W + 1);

   if (NUM_W < 2) begin : g_bad_num
      $error("spi_mon_rate: NUM_W must be at least 2");
   end
   if (NUM_W > OUT_W) begin : g_bad_out
      $error("spi_mon_rate: quotient does not fit OUT_W");
   end

   logic             busy;
   logic [IW-1:0]    steps;
   logic [NUM_W-1:0] numr;
   logic [NUM_W-1:0] quo;
   logic [DEN_W-1:0] rem;
   logic [DEN_W-1:0] dvs;
   logic [DEN_W:0]   rem2;
   logic [DEN_W:0]   diff;
   logic             ge;
   logic [NUM_W-1:0] quo_nx;

   assign rem2   = {rem, numr[NUM_W-1]};
   assign diff   = rem2 - {1'b0, dvs};
   assign ge     = (rem2 >= {1'b0, dvs});
   assign quo_nx = {quo[NUM_W-2:0], ge};

   // Restoring division, one quotient bit per cycle; a new start restarts it.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         steps <= '0;
         numr  <= '0;
         quo   <= '0;
         rem   <= '0;
         dvs   <= '0;
         rate  <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            busy  <= 1'b1;
            steps <= IW'(NUM_W);
            numr  <= NUM[NUM_W-1:0];
            quo   <= '0;
            rem   <= '0;
            dvs   <= den;
         end else if (busy) begin
            rem   <= ge ? diff[DEN_W-1:0] : rem2[DEN_W-1:0];
            quo   <= quo_nx;
            numr  <= {numr[NUM_W-2:0], 1'b0};
            steps <= steps - 1'b1;
            if (steps == IW'(1)) begin
               busy <= 1'b0;
               done <= 1'b1;
               rate <= OUT_W'(quo_nx);
            end
         end
      end
   end

   // R10: each result is a single-cycle pulse
   p_rate_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10: a result is only produced once the divider has gone idle
   p_rate_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

endmodule

// File: rtl/spi_bus_monitor.sv
module spi_bus_monitor
   import spi_mon_pkg::*;
#(
   parameter int          WORD_BITS   = 8,
   parameter int          TS_W        = 32,
   parameter int          RATE_W      = 32,
   parameter logic [63:0] CLK_HZ      = 64'd200000000,
   parameter int          SYNC_STAGES = 2,
   parameter bit          HAS_MOSI    = 1'b1,
   parameter bit          HAS_MISO    = 1'b1,
   parameter bit          HAS_CS      = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_cpol,
   input  logic                 cfg_cpha,
   input  logic                 cfg_cs_act_high,
   input  logic                 cfg_lsb_first,
   input  logic                 bus_sclk,
   input  logic                 bus_mosi,
   input  logic                 bus_miso,
   input  logic                 bus_cs,
   output logic                 word_vld,
   output logic [WORD_BITS-1:0] word_mosi,
   output logic [WORD_BITS-1:0] word_miso,
   output logic                 word_mosi_ok,
   output logic                 word_miso_ok,
   output logic [TS_W-1:0]      word_t_start,
   output logic [TS_W-1:0]      word_t_end,
   output logic                 word_warn,
   output logic                 cs_evt_vld,
   output logic [1:0]           cs_evt_old,
   output logic [1:0]           cs_evt_new,
   output logic                 rate_vld,
   output logic [RATE_W-1:0]    rate_bps
);

   localparam int          CNT_W  = $clog2(WORD_BITS + 1);
   localparam int          FILL_W = $clog2(SYNC_STAGES + 1);
   localparam logic [63:0] NUM    = 64'(WORD_BITS) * CLK_HZ;
   localparam int          NUM_W  = $clog2(NUM + 64'd1);

   if (WORD_BITS < 1) begin : g_bad_word
      $error("spi_bus_monitor: WORD_BITS must be at least 1");
   end
   if (!(HAS_MOSI || HAS_MISO)) begin : g_no_lane
      $error("spi_bus_monitor: at least one data lane is required");
   end
   if (TS_W < 8) begin : g_bad_ts
      $error("spi_bus_monitor: TS_W must be at least 8");
   end
   if (CLK_HZ == 64'd0) begin : g_bad_hz
      $error("spi_bus_monitor: CLK_HZ must be non-zero");
   end

   // ---------------- input synchronisation ----------------
   logic [3:0] pins_s;
   logic       sclk_s, mosi_s, miso_s, cs_s;

   spi_mon_sync #(.N(4), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({bus_cs, bus_miso, bus_mosi, bus_sclk}),
      .q     (pins_s)
   );
   assign {cs_s, miso_s, mosi_s, sclk_s} = pins_s;

   // ---------------- arming after the synchronisers fill ----------------
   logic              armed;
   logic [FILL_W-1:0] fill;
   logic              arm_now;

   assign arm_now = !armed && (fill == FILL_W'(SYNC_STAGES));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
         fill  <= '0;
      end else if (!armed) begin
         if (arm_now) armed <= 1'b1;
         else         fill  <= fill + 1'b1;
      end
   end

   // ---------------- edge detection ----------------
   logic prev_sclk, prev_cs;
   logic rise, fall, samp;
   logic cs_chg, cs_inact;
   cs_code_t cs_now_code;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_sclk <= 1'b0;
         prev_cs   <= 1'b0;
      end else begin
         prev_sclk <= sclk_s;
         prev_cs   <= cs_s;
      end
   end

   assign rise = armed &  sclk_s & ~prev_sclk;
   assign fall = armed & ~sclk_s &  prev_sclk;
   assign samp = (cfg_cpol ^ cfg_cpha) ? fall : rise;

   if (HAS_CS) begin : g_cs
      assign cs_chg      = armed & (cs_s ^ prev_cs);
      assign cs_inact    = cfg_cs_act_high ? ~cs_s : cs_s;
      assign cs_now_code = cs_level_code(cs_s);
   end else begin : g_no_cs
      assign cs_chg      = 1'b0;
      assign cs_inact    = 1'b0;
      assign cs_now_code = CS_CODE_UNKNOWN;
   end

   // ---------------- bit counting ----------------
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] eff_cnt;
   logic             first_bit, last_bit, done;

   assign eff_cnt   = cs_chg ? '0 : cnt;
   assign first_bit = (eff_cnt == '0);
   assign last_bit  = (eff_cnt == CNT_W'(WORD_BITS - 1));
   assign done      = samp & last_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (samp)   cnt <= last_bit ? '0 : eff_cnt + 1'b1;
      else if (cs_chg) cnt <= '0;
   end

   // ---------------- data lanes ----------------
   logic [WORD_BITS-1:0] mosi_nx, miso_nx;

   if (HAS_MOSI) begin : g_mosi
      spi_mon_lane #(.W(WORD_BITS), .IW(CNT_W)) u_lane (
         .clk       (clk),
         .rst_n     (rst_n),
         .clr       (cs_chg),
         .take      (samp),
         .first     (first_bit),
         .idx       (eff_cnt),
         .lsb_first (cfg_lsb_first),
         .bit_in    (mosi_s),
         .word_nx   (mosi_nx)
      );
   end else begin : g_no_mosi
      assign mosi_nx = '0;
   end

   if (HAS_MISO) begin : g_miso
      spi_mon_lane #(.W(WORD_BITS), .IW(CNT_W)) u_lane (
         .clk       (clk),
         .rst_n     (rst_n),
         .clr       (cs_chg),
         .take      (samp),
         .first     (first_bit),
         .idx       (eff_cnt),
         .lsb_first (cfg_lsb_first),
         .bit_in    (miso_s),
         .word_nx   (miso_nx)
      );
   end else begin : g_no_miso
      assign miso_nx = '0;
   end

   assign word_mosi_ok = HAS_MOSI;
   assign word_miso_ok = HAS_MISO;

   // ---------------- timestamps ----------------
   logic [TS_W-1:0] now;
   logic [TS_W-1:0] t_first;
   logic [TS_W-1:0] t0_eff;
   logic [TS_W-1:0] span;
   logic            warn_acc;

   assign t0_eff = first_bit ? now : t_first;
   assign span   = now - t0_eff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         now      <= '0;
         t_first  <= '0;
         warn_acc <= 1'b0;
      end else begin
         now <= now + 1'b1;
         if (samp && first_bit) begin
            t_first  <= now;
            warn_acc <= cs_inact;
         end
      end
   end

   // ---------------- word output ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_vld     <= 1'b0;
         word_mosi    <= '0;
         word_miso    <= '0;
         word_t_start <= '0;
         word_t_end   <= '0;
         word_warn    <= 1'b0;
      end else begin
         word_vld <= done;
         if (done) begin
            word_mosi    <= mosi_nx;
            word_miso    <= miso_nx;
            word_t_start <= t0_eff;
            word_t_end   <= now + span;
            word_warn    <= first_bit ? cs_inact : warn_acc;
         end
      end
   end

   // ---------------- chip-select events ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_evt_vld <= 1'b0;
         cs_evt_old <= CS_CODE_UNKNOWN;
         cs_evt_new <= CS_CODE_UNKNOWN;
      end else begin
         cs_evt_vld <= arm_now | cs_chg;
         if (arm_now) begin
            cs_evt_old <= CS_CODE_UNKNOWN;
            cs_evt_new <= cs_now_code;
         end else if (cs_chg) begin
            cs_evt_old <= cs_level_code(prev_cs);
            cs_evt_new <= cs_now_code;
         end
      end
   end

   // ---------------- bit rate ----------------
   spi_mon_rate #(
      .NUM   (NUM),
      .NUM_W (NUM_W),
      .DEN_W (TS_W),
      .OUT_W (RATE_W)
   ) u_rate (
      .clk   (clk),
      .rst_n (rst_n),
      .start (done),
      .den   (span + TS_W'(1)),
      .rate  (rate_bps),
      .done  (rate_vld)
   );

   // ---------------- assertions ----------------
   // R3: the bit counter never reaches the word length
   p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < CNT_W'(WORD_BITS));

   // R1: without a serial-clock change or a chip-select change, no bit is counted
   p_no_edge_no_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk_s == prev_sclk && !cs_chg) |=> $stable(cnt));

   // R5: every event after the initial one reports a real level change
   p_evt_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_evt_vld && cs_evt_old != CS_CODE_UNKNOWN) |-> (cs_evt_old != cs_evt_new));

   // R6: arming produces the initial event with an unknown old level
   p_init_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
      arm_now |=> (cs_evt_vld && cs_evt_old == CS_CODE_UNKNOWN));

   // R9: the end stamp lies an even number of cycles after the start stamp
   p_span_even_r9: assert property (@(posedge clk) disable iff (!rst_n)
      word_vld |-> (((word_t_end - word_t_start) & TS_W'(1)) == '0));

endmodule

// File: tb/spi_bus_monitor_test.sv
`timescale 1ns/1ps
module spi_bus_monitor_test;

   localparam int W = 8;
   localparam int P = 8;   // serial clock period in system cycles
   localparam int H = P / 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_cs_act_high = 1'b0, cfg_lsb_first = 1'b0;
   logic bus_sclk = 1'b0, bus_mosi = 1'b0, bus_miso = 1'b0, bus_cs = 1'b1;

   logic          word_vld, word_mosi_ok, word_miso_ok, word_warn;
   logic [W-1:0]  word_mosi, word_miso;
   logic [31:0]   word_t_start, word_t_end, rate_bps;
   logic          cs_evt_vld, rate_vld;
   logic [1:0]    cs_evt_old, cs_evt_new;

   logic          nc_word_vld, nc_mosi_ok, nc_miso_ok, nc_warn, nc_evt_vld, nc_rate_vld;
   logic [W-1:0]  nc_mosi, nc_miso;
   logic [31:0]   nc_ts, nc_te, nc_rate;
   logic [1:0]    nc_old, nc_new;

   always #2.5 clk = ~clk;

   spi_bus_monitor uut (
      .clk(clk), .rst_n(rst_n),
      .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
      .cfg_cs_act_high(cfg_cs_act_high), .cfg_lsb_first(cfg_lsb_first),
      .bus_sclk(bus_sclk), .bus_mosi(bus_mosi), .bus_miso(bus_miso), .bus_cs(bus_cs),
      .word_vld(word_vld), .word_mosi(word_mosi), .word_miso(word_miso),
      .word_mosi_ok(word_mosi_ok), .word_miso_ok(word_miso_ok),
      .word_t_start(word_t_start), .word_t_end(word_t_end), .word_warn(word_warn),
      .cs_evt_vld(cs_evt_vld), .cs_evt_old(cs_evt_old), .cs_evt_new(cs_evt_new),
      .rate_vld(rate_vld), .rate_bps(rate_bps)
   );

   spi_bus_monitor #(.HAS_CS(1'b0), .HAS_MISO(1'b0)) uut_lean (
      .clk(clk), .rst_n(rst_n),
      .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
      .cfg_cs_act_high(cfg_cs_act_high), .cfg_lsb_first(cfg_lsb_first),
      .bus_sclk(bus_sclk), .bus_mosi(bus_mosi), .bus_miso(bus_miso), .bus_cs(bus_cs),
      .word_vld(nc_word_vld), .word_mosi(nc_mosi), .word_miso(nc_miso),
      .word_mosi_ok(nc_mosi_ok), .word_miso_ok(nc_miso_ok),
      .word_t_start(nc_ts), .word_t_end(nc_te), .word_warn(nc_warn),
      .cs_evt_vld(nc_evt_vld), .cs_evt_old(nc_old), .cs_evt_new(nc_new),
      .rate_vld(nc_rate_vld), .rate_bps(nc_rate)
   );

   // ---------------- result capture ----------------
   int          n_cmp = 0, n_bad = 0;
   int          n_words = 0, n_evt = 0, n_rate = 0;
   logic [W-1:0] last_mosi, last_miso;
   logic        last_warn;
   logic [31:0] last_start = 0, prev_start = 0, last_span = 0, last_rate = 0;
   logic [1:0]  last_old, last_new, first_old, first_new;
   int          nc_words = 0, nc_evts = 0, nc_bad_lane = 0;
   logic [1:0]  nc_first_old, nc_first_new;

   always @(negedge clk) begin
      if (word_vld) begin
         n_words++;
         last_mosi  = word_mosi;
         last_miso  = word_miso;
         last_warn  = word_warn;
         prev_start = last_start;
         last_start = word_t_start;
         last_span  = word_t_end - word_t_start;
      end
      if (cs_evt_vld) begin
         if (n_evt == 0) begin
            first_old = cs_evt_old;
            first_new = cs_evt_new;
         end
         n_evt++;
         last_old = cs_evt_old;
         last_new = cs_evt_new;
      end
      if (rate_vld) begin
         n_rate++;
         last_rate = rate_bps;
      end
      if (nc_word_vld) begin
         nc_words++;
         if (nc_miso_ok !== 1'b0 || nc_miso !== '0 || nc_mosi_ok !== 1'b1 || nc_warn !== 1'b0)
            nc_bad_lane++;
      end
      if (nc_evt_vld) begin
         if (nc_evts == 0) begin
            nc_first_old = nc_old;
            nc_first_new = nc_new;
         end
         nc_evts++;
      end
   end

   // ---------------- helpers ----------------
   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input string what, input longint act, input longint exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Sends nbits of a transfer; bit k carries d[k] (lsb) or d[W-1-k] (msb).
   // cs_lvl_first >= 0 drives chip select to that level with the first leading edge.
   task automatic send(input logic cpha, input logic lsb, input logic [W-1:0] mo,
                       input logic [W-1:0] mi, input int nbits, input int cs_lvl_first);
      for (int k = 0; k < nbits; k++) begin
         int b = lsb ? k : W - 1 - k;
         if (cpha == 1'b0) begin
            if (k == 0) begin
               bus_mosi = mo[b];
               bus_miso = mi[b];
               tick(H);
            end
            bus_sclk = ~bus_sclk;
            if (k == 0 && cs_lvl_first >= 0) bus_cs = cs_lvl_first[0];
            tick(H);
            bus_sclk = ~bus_sclk;
            if (k + 1 < nbits) begin
               int nb = lsb ? k + 1 : W - 2 - k;
               bus_mosi = mo[nb];
               bus_miso = mi[nb];
            end
            tick(H);
         end else begin
            bus_sclk = ~bus_sclk;
            if (k == 0 && cs_lvl_first >= 0) bus_cs = cs_lvl_first[0];
            bus_mosi = mo[b];
            bus_miso = mi[b];
            tick(H);
            bus_sclk = ~bus_sclk;
            tick(H);
         end
      end
   endtask

   task automatic set_mode(input logic cpol, input logic cpha, input logic lsb, input logic csah);
      cfg_cpol = cpol;
      cfg_cpha = cpha;
      cfg_lsb_first = lsb;
      cfg_cs_act_high = csah;
      bus_sclk = cpol;
      bus_cs = ~csah;
      tick(12);
   endtask

   // {cpol, cpha, lsb_first, cs_act_high, mosi byte, miso byte}
   localparam logic [19:0] VEC [6] = '{
      {4'b0000, 8'hA5, 8'h3C},
      {4'b0100, 8'h96, 8'hE1},
      {4'b1010, 8'h0F, 8'h81},
      {4'b1111, 8'hC3, 8'h5A},
      {4'b0011, 8'h01, 8'h80},
      {4'b1100, 8'h7E, 8'h24}
   };

   localparam longint EXP_RATE = (longint'(W) * 64'd200000000) / longint'((W - 1) * P + 1);

   bit finished = 1'b0;

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      int w0, e0, r0;
      // ---------------- reset ----------------
      tick(5);
      check("R3", "word_vld in reset", word_vld, 0);
      check("R5", "cs_evt_vld in reset", cs_evt_vld, 0);
      check("R10", "rate_vld in reset", rate_vld, 0);
      rst_n = 1'b1;
      tick(10);
      check("R6", "initial event count", n_evt, 1);
      check("R6", "initial old code", first_old, 2'b10);
      check("R6", "initial new code", first_new, 2'b01);
      check("R6", "no-cs event count", nc_evts, 1);
      check("R6", "no-cs old code", nc_first_old, 2'b10);
      check("R6", "no-cs new code", nc_first_new, 2'b10);

      // ---------------- vector walk: R1 R2 R4 R9 R10 ----------------
      for (int v = 0; v < 6; v++) begin
         logic cpol = VEC[v][19], cpha = VEC[v][18], lsb = VEC[v][17], csah = VEC[v][16];
         logic [W-1:0] mo = VEC[v][15:8], mi = VEC[v][7:0];
         set_mode(cpol, cpha, lsb, csah);
         e0 = n_evt;
         bus_cs = csah;
         tick(8);
         check("R5", "event on assert", n_evt, e0 + 1);
         check("R5", "new level code", last_new, {1'b0, csah});
         check("R2", "old level code", last_old, {1'b0, ~csah});
         w0 = n_words;
         r0 = n_rate;
         send(cpha, lsb, mo, mi, W, -1);
         tick(6);
         check("R3", "one word per transfer", n_words, w0 + 1);
         check("R1", "mosi word", last_mosi, mo);
         check("R4", "miso word", last_miso, mi);
         check("R2", "warn with active cs", last_warn, 0);
         check("R9", "end minus start", last_span, 2 * (W - 1) * P);
         tick(45);
         check("R10", "rate count", n_rate, r0 + 1);
         check("R10", "rate value", last_rate, EXP_RATE);
         bus_cs = ~csah;
         tick(8);
         check("R5", "event on release", last_new, {1'b0, ~csah});
      end

      // ---------------- back-to-back words: R3 R9 ----------------
      set_mode(1'b0, 1'b1, 1'b0, 1'b0);
      bus_cs = 1'b0;
      tick(8);
      w0 = n_words;
      send(1'b1, 1'b0, 8'h5C, 8'hA1, W, -1);
      send(1'b1, 1'b0, 8'h3E, 8'h77, W, -1);
      tick(6);
      check("R3", "two words", n_words, w0 + 2);
      check("R3", "second mosi word", last_mosi, 8'h3E);
      check("R3", "second miso word", last_miso, 8'h77);
      check("R9", "start spacing", last_start - prev_start, W * P);
      bus_cs = 1'b1;
      tick(8);

      // ---------------- partial word cleared by cs: R5 ----------------
      set_mode(1'b0, 1'b0, 1'b0, 1'b0);
      bus_cs = 1'b0;
      tick(8);
      w0 = n_words;
      send(1'b0, 1'b0, 8'hFF, 8'hFF, 3, -1);
      tick(4);
      bus_cs = 1'b1;
      tick(8);
      check("R5", "release old code", last_old, 2'b00);
      check("R5", "release new code", last_new, 2'b01);
      bus_cs = 1'b0;
      tick(8);
      send(1'b0, 1'b0, 8'h12, 8'h34, W, -1);
      tick(6);
      check("R5", "no stale word", n_words, w0 + 1);
      check("R5", "mosi after clear", last_mosi, 8'h12);
      check("R5", "miso after clear", last_miso, 8'h34);
      bus_cs = 1'b1;
      tick(8);

      // ---------------- warning with inactive cs: R7 ----------------
      w0 = n_words;
      send(1'b0, 1'b0, 8'h69, 8'h96, W, -1);
      tick(6);
      check("R7", "word while inactive", n_words, w0 + 1);
      check("R7", "warn flag", last_warn, 1);
      check("R7", "data still decoded", last_mosi, 8'h69);

      // ---------------- cs change with first edge: R11 ----------------
      tick(8);
      w0 = n_words;
      e0 = n_evt;
      send(1'b0, 1'b0, 8'hB4, 8'h4B, W, 0);
      tick(6);
      check("R11", "event with edge", n_evt, e0 + 1);
      check("R11", "event new code", last_new, 2'b00);
      check("R11", "one word", n_words, w0 + 1);
      check("R11", "mosi intact", last_mosi, 8'hB4);
      check("R11", "miso intact", last_miso, 8'h4B);
      check("R11", "warn clear", last_warn, 0);
      bus_cs = 1'b1;
      tick(8);

      // ---------------- lane presence: R8 ----------------
      check("R8", "present lanes flagged", {word_mosi_ok, word_miso_ok}, 2'b11);
      check("R8", "lean build produced words", nc_words > 0, 1);
      check("R8", "lean build lane flags and data", nc_bad_lane, 0);
      check("R6", "lean build single event", nc_evts, 1);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule